// File: doc/BRIEF.md
# PCI Bridge Address Window Decoder

This block holds the window registers of a PCI-to-PCI bridge configuration header and decides, for each access seen on the primary side, whether the bridge should claim it and pass it to the secondary bus. Three windows are kept: an I/O window with 4 KB granularity, a 32-bit memory window with 1 MB granularity, and a prefetchable memory window with 1 MB granularity. The I/O window can reach 32 bits and the prefetchable window 64 bits when the matching capability is built in.

Software programs the windows through a small register port. The port has a dword offset, write data, a write strobe, a read strobe and registered read data. Every window register has a low nibble that is fixed at build time to a capability code. That code controls whether the upper-address registers can be written. The access-check port takes an address, a byte count and an I/O-or-memory select. It returns a combinational forward flag, which is also gated by two enable bits in the command register.

Top module: `bridge_window_decoder`

## Requirements
- R1: After reset the command bits are 0, every base and upper-address register reads 0, each limit field reads only its capability code, and no access is forwarded.
- R2: Bits 3:0 of each window base and limit field always read back as the build-time capability code (I/O code in bits 3:0 and 11:8 of dword 7, prefetchable code in bits 3:0 and 19:16 of dword 9); written bits there are dropped.
- R3: The memory window spans from {base[15:4], 20'h0} up to, but excluding, {limit[15:4], 20'h0} + 0x100000.
- R4: The I/O window spans from {upperBase16, base[7:4], 12'h0} up to, but excluding, {upperLimit16, limit[7:4], 12'h0} + 0x1000.
- R5: Writes to the I/O upper-16 dword take effect only when the I/O capability code is 1; otherwise they are dropped and the register reads 0.
- R6: Writes to the prefetchable upper-32 base (dword 10) and limit (dword 11) take effect only when the prefetchable capability code is 1, which forms a 64-bit window; otherwise they are dropped.
- R7: Register layout by dword offset:
  - 1: command, bit 0 enables I/O and bit 1 enables memory.
  - 7: I/O base in byte 0 and I/O limit in byte 1; bits 31:16 read 0.
  - 8: memory base in bits 15:0 and memory limit in bits 31:16.
  - 9: prefetchable base in bits 15:0 and prefetchable limit in bits 31:16.
  - 12: I/O upper base in bits 15:0 and I/O upper limit in bits 31:16.
  - Unmapped offsets read 0.
- R8: An I/O access (select = 1) is forwarded only while command bit 0 is set and the access lies in the I/O window.
- R9: An access is refused when its address is below the window start, or when address plus size is greater than or equal to the window end. An access whose last byte is the final byte of the window is therefore refused.
- R10: A memory access (select = 0) is forwarded only while command bit 1 is set and the access lies in the memory window or the prefetchable window.
- R11: A register write changes the decode from the clock edge that samples the write strobe. Read data is updated on the edge that samples the read strobe and holds while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgAddr | input | 6 | Configuration dword offset |
| cfgWrData | input | 32 | Configuration write data |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgRdEn | input | 1 | Configuration read strobe |
| cfgRdData | output | 32 | Registered configuration read data |
| accAddr | input | 64 | Address of the access being checked |
| accSize | input | SIZE_W | Byte count of the access |
| accIsIo | input | 1 | 1 for an I/O access, 0 for a memory access |
| accFwd | output | 1 | Access is forwarded to the secondary bus |

## Verification
Some properties are checked on every cycle. A forwarded I/O access always lies within the derived I/O bounds and has its command enable set. A forwarded memory access always has its command enable set. The upper address halves stay zero when their capability code is not 1. The capability nibble appears in every I/O dword read, and read data holds between reads. Other behaviour needs directed scenarios: the exact window edges, the exclusive-end quirk, that dropped upper-register writes leave the decode unchanged, and the register packing. The bench uses a full-capability instance and a no-capability instance side by side to show these.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam int unsigned CFG_AW  = 6;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 64;
  localparam int unsigned IO_W    = 32;
  localparam int unsigned MEM_W   = 32;
  localparam int unsigned CMP_W   = ADDR_W + 2;

  localparam logic [CFG_AW-1:0] DW_CMD     = 6'd1;
  localparam logic [CFG_AW-1:0] DW_IO      = 6'd7;
  localparam logic [CFG_AW-1:0] DW_MEM     = 6'd8;
  localparam logic [CFG_AW-1:0] DW_PREF    = 6'd9;
  localparam logic [CFG_AW-1:0] DW_PREF_BH = 6'd10;
  localparam logic [CFG_AW-1:0] DW_PREF_LH = 6'd11;
  localparam logic [CFG_AW-1:0] DW_IO_HI   = 6'd12;

  typedef enum logic [2:0] {
    RD_NONE, RD_CMD, RD_IO, RD_MEM, RD_PREF, RD_PBHI, RD_PLHI, RD_IOHI
  } rdSel_e;

  typedef struct packed {
    logic   wrCmd;
    logic   wrIo;
    logic   wrMem;
    logic   wrPref;
    logic   wrPrefBaseHi;
    logic   wrPrefLimHi;
    logic   wrIoHi;
    logic   rdEn;
    rdSel_e rdSel;
  } strobe_t;

  typedef struct packed {
    logic [IO_W-1:0]     ioStart;
    logic [IO_W:0]       ioEnd;
    logic [MEM_W-1:0]    memStart;
    logic [MEM_W:0]      memEnd;
    logic [ADDR_W-1:0]   prefStart;
    logic [ADDR_W:0]     prefEnd;
  } window_t;
endpackage

// File: rtl/bwd_ctrl.sv
module bwd_ctrl
  import bwd_pkg::*;
(
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic              cfgWrEn,
  input  logic              cfgRdEn,
  output strobe_t           strobe
);
  always_comb begin
    strobe = '0;
    strobe.rdEn = cfgRdEn;
    unique case (cfgAddr)
      DW_CMD:     begin strobe.wrCmd        = cfgWrEn; strobe.rdSel = RD_CMD;  end
      DW_IO:      begin strobe.wrIo         = cfgWrEn; strobe.rdSel = RD_IO;   end
      DW_MEM:     begin strobe.wrMem        = cfgWrEn; strobe.rdSel = RD_MEM;  end
      DW_PREF:    begin strobe.wrPref       = cfgWrEn; strobe.rdSel = RD_PREF; end
      DW_PREF_BH: begin strobe.wrPrefBaseHi = cfgWrEn; strobe.rdSel = RD_PBHI; end
      DW_PREF_LH: begin strobe.wrPrefLimHi  = cfgWrEn; strobe.rdSel = RD_PLHI; end
      DW_IO_HI:   begin strobe.wrIoHi       = cfgWrEn; strobe.rdSel = RD_IOHI; end
      default:    strobe.rdSel = RD_NONE;
    endcase
  end
endmodule

// File: rtl/bwd_regs.sv
module bwd_regs
  import bwd_pkg::*;
#(
  parameter logic [3:0]  IO_CAP    = 4'd1,
  parameter logic [3:0]  MEM_CAP   = 4'd0,
  parameter logic [3:0]  PREF_CAP  = 4'd1,
  parameter logic [7:0]  IO_MASK   = 8'hF0,
  parameter logic [15:0] MEM_MASK  = 16'hFFF0,
  parameter logic [15:0] PREF_MASK = 16'hFFF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [1:0]        cmdBits,
  output window_t           win
);
  localparam int unsigned IO_HI_W  = IO_W - 16;
  localparam int unsigned PREF_HI_W = ADDR_W - MEM_W;

  logic [3:0]  ioBaseN, ioLimN;
  logic [11:0] memBaseN, memLimN, prefBaseN, prefLimN;
  logic [IO_HI_W-1:0]   ioBaseHi, ioLimHi;
  logic [PREF_HI_W-1:0] prefBaseHi, prefLimHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdBits   <= '0;
      ioBaseN   <= '0;
      ioLimN    <= '0;
      memBaseN  <= '0;
      memLimN   <= '0;
      prefBaseN <= '0;
      prefLimN  <= '0;
    end else begin
      if (strobe.wrCmd) cmdBits <= wrData[1:0];
      if (strobe.wrIo) begin
        ioBaseN <= wrData[7:4]   & IO_MASK[7:4];
        ioLimN  <= wrData[15:12] & IO_MASK[7:4];
      end
      if (strobe.wrMem) begin
        memBaseN <= wrData[15:4]  & MEM_MASK[15:4];
        memLimN  <= wrData[31:20] & MEM_MASK[15:4];
      end
      if (strobe.wrPref) begin
        prefBaseN <= wrData[15:4]  & PREF_MASK[15:4];
        prefLimN  <= wrData[31:20] & PREF_MASK[15:4];
      end
    end
  end

  generate
    if (IO_CAP == 4'd1) begin : g_io32
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          ioBaseHi <= '0;
          ioLimHi  <= '0;
        end else if (strobe.wrIoHi) begin
          ioBaseHi <= wrData[15:0];
          ioLimHi  <= wrData[31:16];
        end
      end
    end else begin : g_io16
      assign ioBaseHi = '0;
      assign ioLimHi  = '0;
    end

    if (PREF_CAP == 4'd1) begin : g_pref64
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          prefBaseHi <= '0;
          prefLimHi  <= '0;
        end else begin
          if (strobe.wrPrefBaseHi) prefBaseHi <= wrData;
          if (strobe.wrPrefLimHi)  prefLimHi  <= wrData;
        end
      end
    end else begin : g_pref32
      assign prefBaseHi = '0;
      assign prefLimHi  = '0;
    end
  endgenerate

  always_comb begin
    win.ioStart   = {ioBaseHi, ioBaseN, 12'h000};
    win.ioEnd     = {1'b0, ioLimHi, ioLimN, 12'h000} + 33'h1000;
    win.memStart  = {memBaseN, 20'h00000};
    win.memEnd    = {1'b0, memLimN, 20'h00000} + 33'h100000;
    win.prefStart = {prefBaseHi, prefBaseN, 20'h00000};
    win.prefEnd   = {1'b0, prefLimHi, prefLimN, 20'h00000} + 65'h100000;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobe.rdEn) begin
      unique case (strobe.rdSel)
        RD_CMD:  rdData <= {30'h0, cmdBits};
        RD_IO:   rdData <= {16'h0, ioLimN, IO_CAP, ioBaseN, IO_CAP};
        RD_MEM:  rdData <= {memLimN, MEM_CAP, memBaseN, MEM_CAP};
        RD_PREF: rdData <= {prefLimN, PREF_CAP, prefBaseN, PREF_CAP};
        RD_PBHI: rdData <= prefBaseHi;
        RD_PLHI: rdData <= prefLimHi;
        RD_IOHI: rdData <= {ioLimHi, ioBaseHi};
        default: rdData <= '0;
      endcase
    end
  end

  logic unusedBits;
  assign unusedBits = ^{wrData[3:2], wrData[11:8], wrData[19:16]};
endmodule

// File: rtl/bwd_match.sv
module bwd_match
  import bwd_pkg::*;
#(
  parameter int unsigned SIZE_W = 4
) (
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [SIZE_W-1:0] accSize,
  input  logic              accIsIo,
  input  logic [1:0]        cmdBits,
  input  window_t           win,
  output logic              accFwd
);
  logic [CMP_W-1:0] aLo, aHi;
  logic ioHit, memHit, prefHit;

  function automatic logic inWindow(input logic [CMP_W-1:0] lo, hi, wStart, wEnd);
    return (lo >= wStart) && (hi < wEnd);
  endfunction

  always_comb begin
    aLo     = {2'b00, accAddr};
    aHi     = aLo + {{(CMP_W-SIZE_W){1'b0}}, accSize};
    ioHit   = inWindow(aLo, aHi, {{(CMP_W-IO_W){1'b0}}, win.ioStart},
                       {{(CMP_W-IO_W-1){1'b0}}, win.ioEnd});
    memHit  = inWindow(aLo, aHi, {{(CMP_W-MEM_W){1'b0}}, win.memStart},
                       {{(CMP_W-MEM_W-1){1'b0}}, win.memEnd});
    prefHit = inWindow(aLo, aHi, {2'b00, win.prefStart}, {1'b0, win.prefEnd});
    if (accIsIo) accFwd = cmdBits[0] && ioHit;
    else         accFwd = cmdBits[1] && (memHit || prefHit);
  end
endmodule

// File: rtl/bridge_window_decoder.sv
module bridge_window_decoder
  import bwd_pkg::*;
#(
  parameter logic [3:0]  IO_CAP    = 4'd1,
  parameter logic [3:0]  MEM_CAP   = 4'd0,
  parameter logic [3:0]  PREF_CAP  = 4'd1,
  parameter logic [7:0]  IO_MASK   = 8'hF0,
  parameter logic [15:0] MEM_MASK  = 16'hFFF0,
  parameter logic [15:0] PREF_MASK = 16'hFFF0,
  parameter int unsigned SIZE_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [5:0]        cfgAddr,
  input  logic [31:0]       cfgWrData,
  input  logic              cfgWrEn,
  input  logic              cfgRdEn,
  output logic [31:0]       cfgRdData,
  input  logic [63:0]       accAddr,
  input  logic [SIZE_W-1:0] accSize,
  input  logic              accIsIo,
  output logic              accFwd
);
  strobe_t    strobe;
  logic [1:0] cmdBits;
  window_t    win;

  bwd_ctrl i_ctrl (
    .cfgAddr (cfgAddr),
    .cfgWrEn (cfgWrEn),
    .cfgRdEn (cfgRdEn),
    .strobe  (strobe)
  );

  bwd_regs #(
    .IO_CAP(IO_CAP), .MEM_CAP(MEM_CAP), .PREF_CAP(PREF_CAP),
    .IO_MASK(IO_MASK), .MEM_MASK(MEM_MASK), .PREF_MASK(PREF_MASK)
  ) i_regs (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (cfgWrData),
    .rdData  (cfgRdData),
    .cmdBits (cmdBits),
    .win     (win)
  );

  bwd_match #(.SIZE_W(SIZE_W)) i_match (
    .accAddr (accAddr),
    .accSize (accSize),
    .accIsIo (accIsIo),
    .cmdBits (cmdBits),
    .win     (win),
    .accFwd  (accFwd)
  );
endmodule

// File: rtl/bwd_checker.sv
module bwd_checker
  import bwd_pkg::*;
#(
  parameter logic [3:0]  IO_CAP   = 4'd1,
  parameter logic [3:0]  PREF_CAP = 4'd1,
  parameter int unsigned SIZE_W   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [5:0]        cfgAddr,
  input logic              cfgRdEn,
  input logic [31:0]       cfgRdData,
  input logic [63:0]       accAddr,
  input logic [SIZE_W-1:0] accSize,
  input logic              accIsIo,
  input logic              accFwd,
  input logic [1:0]        cmdBits,
  input window_t           win
);
  logic [CMP_W-1:0] aLo, aHi;
  assign aLo = {2'b00, accAddr};
  assign aHi = aLo + {{(CMP_W-SIZE_W){1'b0}}, accSize};

  AST_IO_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (accIsIo && accFwd) |-> cmdBits[0]); // R8
  AST_MEM_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!accIsIo && accFwd) |-> cmdBits[1]); // R10
  AST_IO_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (accIsIo && accFwd) |-> ((aLo >= {34'h0, win.ioStart}) && (aHi < {33'h0, win.ioEnd}))); // R9
  AST_IO_CAP_NIBBLE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdEn && cfgAddr == DW_IO) |=> (cfgRdData[3:0] == IO_CAP && cfgRdData[11:8] == IO_CAP)); // R2
  AST_IO_HI_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (IO_CAP != 4'd1) |-> (win.ioStart[31:16] == 16'h0 && win.ioEnd[32:16] <= 17'h1)); // R5
  AST_PREF_HI_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (PREF_CAP != 4'd1) |-> (win.prefStart[63:32] == 32'h0)); // R6
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRdEn |=> $stable(cfgRdData)); // R11
endmodule

bind bridge_window_decoder bwd_checker #(
  .IO_CAP(IO_CAP), .PREF_CAP(PREF_CAP), .SIZE_W(SIZE_W)
) i_bwd_checker (
  .clk(clk), .rstN(rstN), .cfgAddr(cfgAddr), .cfgRdEn(cfgRdEn),
  .cfgRdData(cfgRdData), .accAddr(accAddr), .accSize(accSize),
  .accIsIo(accIsIo), .accFwd(accFwd), .cmdBits(cmdBits), .win(win)
);

// File: tb/test_bridge_window_decoder.sv
module test_bridge_window_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic        cfgWrEn = 1'b0;
  logic        cfgRdEn = 1'b0;
  logic [31:0] rdFull, rdBare;
  logic [63:0] accAddr = '0;
  logic [3:0]  accSize = '0;
  logic        accIsIo = 1'b0;
  logic        fwdFull, fwdBare;
  int nChecks = 0;
  int nFails  = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bridge_window_decoder i_bridge_window_decoder (
    .clk(clk), .rstN(rstN), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .cfgWrEn(cfgWrEn), .cfgRdEn(cfgRdEn), .cfgRdData(rdFull),
    .accAddr(accAddr), .accSize(accSize), .accIsIo(accIsIo), .accFwd(fwdFull)
  );

  bridge_window_decoder #(.IO_CAP(4'd0), .PREF_CAP(4'd0)) i_bridge_window_decoder_bare (
    .clk(clk), .rstN(rstN), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .cfgWrEn(cfgWrEn), .cfgRdEn(cfgRdEn), .cfgRdData(rdBare),
    .accAddr(accAddr), .accSize(accSize), .accIsIo(accIsIo), .accFwd(fwdBare)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgAddr = a; cfgWrData = d; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic cfgRead(input logic [5:0] a);
    @(negedge clk);
    cfgAddr = a; cfgRdEn = 1'b1;
    @(negedge clk);
    cfgRdEn = 1'b0;
  endtask

  task automatic probe(input logic [63:0] a, input logic [3:0] s, input logic io);
    @(negedge clk);
    accAddr = a; accSize = s; accIsIo = io;
    #1;
  endtask

  task automatic t_reset;
    cfgRead(6'd7);
    check("R1 io dword full", rdFull, 32'h0000_0101);
    check("R1 io dword bare", rdBare, 32'h0);
    cfgRead(6'd9);
    check("R1 pref dword", rdFull, 32'h0001_0001);
    cfgRead(6'd1);
    check("R1 command", rdFull, 32'h0);
    probe(64'h0, 4'd1, 1'b1);
    check("R1 io not forwarded", fwdFull, 1'b0);
    probe(64'h0, 4'd1, 1'b0);
    check("R1 mem not forwarded", fwdFull, 1'b0);
  endtask

  task automatic t_nibble;
    cfgWrite(6'd7, 32'hFFFF_FFFF);
    cfgRead(6'd7);
    check("R2 R7 io nibble full", rdFull, 32'h0000_F1F1);
    check("R2 io nibble bare", rdBare, 32'h0000_F0F0);
    cfgWrite(6'd9, 32'h1230_4560);
    cfgRead(6'd9);
    check("R2 R7 pref nibble", rdFull, 32'h1231_4561);
    cfgRead(6'd40);
    check("R7 unmapped", rdFull, 32'h0);
  endtask

  task automatic t_io;
    cfgWrite(6'd1, 32'h1);
    cfgWrite(6'd7, 32'h0000_3020);
    probe(64'h2000, 4'd2, 1'b1);
    check("R4 io start", fwdFull, 1'b1);
    probe(64'h1FFF, 4'd1, 1'b1);
    check("R4 io below", fwdFull, 1'b0);
    probe(64'h3FF0, 4'd4, 1'b1);
    check("R4 io inside end", fwdFull, 1'b1);
    probe(64'h3FFC, 4'd4, 1'b1);
    check("R9 io touching end", fwdFull, 1'b0);
    probe(64'h2000, 4'd2, 1'b0);
    check("R10 mem disabled", fwdFull, 1'b0);
    cfgWrite(6'd12, 32'h0005_0005);
    cfgRead(6'd12);
    check("R5 R7 io upper full", rdFull, 32'h0005_0005);
    check("R5 io upper bare", rdBare, 32'h0);
    probe(64'h5_2000, 4'd1, 1'b1);
    check("R4 io 32-bit window", fwdFull, 1'b1);
    probe(64'h2000, 4'd1, 1'b1);
    check("R4 io old window gone", fwdFull, 1'b0);
    check("R5 bare keeps 16-bit window", fwdBare, 1'b1);
  endtask

  task automatic t_mem;
    cfgWrite(6'd1, 32'h2);
    cfgWrite(6'd8, 32'h10F0_1000);
    probe(64'h1000_0000, 4'd4, 1'b0);
    check("R3 mem start", fwdFull, 1'b1);
    probe(64'h0FFF_FFFC, 4'd4, 1'b0);
    check("R3 mem below", fwdFull, 1'b0);
    probe(64'h10FF_FFF8, 4'd4, 1'b0);
    check("R3 mem inside end", fwdFull, 1'b1);
    probe(64'h10FF_FFFC, 4'd4, 1'b0);
    check("R9 mem touching end", fwdFull, 1'b0);
    probe(64'h5_2000, 4'd1, 1'b1);
    check("R8 io disabled", fwdFull, 1'b0);
  endtask

  task automatic t_pref;
    cfgWrite(6'd9, 32'h0);
    cfgWrite(6'd10, 32'h1);
    cfgWrite(6'd11, 32'h1);
    cfgRead(6'd10);
    check("R6 pref upper base full", rdFull, 32'h1);
    check("R6 pref upper base bare", rdBare, 32'h0);
    probe(64'h1_0000_0000, 4'd8, 1'b0);
    check("R6 pref 64-bit hit", fwdFull, 1'b1);
    check("R6 bare no 64-bit", fwdBare, 1'b0);
    probe(64'h1_000F_FFF8, 4'd8, 1'b0);
    check("R9 pref touching end", fwdFull, 1'b0);
    probe(64'h10, 4'd4, 1'b0);
    check("R6 low pref miss full", fwdFull, 1'b0);
    check("R10 bare pref low hit", fwdBare, 1'b1);
  endtask

  task automatic t_timing;
    cfgRead(6'd8);
    check("R7 mem dword", rdFull, 32'h10F0_1000);
    cfgWrite(6'd8, 32'h2000_2000);
    check("R11 read data holds", rdFull, 32'h10F0_1000);
    probe(64'h2000_0000, 4'd4, 1'b0);
    check("R11 new mem window live", fwdFull, 1'b1);
    probe(64'h1000_0000, 4'd4, 1'b0);
    check("R11 old mem window gone", fwdFull, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset;
    t_nibble;
    t_io;
    t_mem;
    t_pref;
    t_timing;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule